// File: doc/BRIEF.md
# Timer/Event Counter with Pulse-Width Capture

This block is an up-counting timer/event counter that sits on a small register bus. One control register sets its behaviour. The counter can run in three modes. In timer mode it counts ticks from one of two internal tick sources. In event mode it counts edges of an external pin. In pulse-width mode it counts internal ticks while the pin is in a chosen phase.

Software programs a reload value. The counter returns to that value each time it rolls over past all ones. A sticky overflow flag records the rollover and stays set until software clears it. In pulse-width mode the hardware drops the run bit when the measured phase ends, so the captured width is held until software reads it. The external pin passes through a synchronizer before any edge on it is recognised.

Top module: `tmr_evt_ctr`

## Requirements
- R1: The control register at address 0 holds bits 7:3. Bits 2:0 always read back as zero.
- R2: When control bits 7:6 are 00, the counter does not change, whatever the ticks or the pin do.
- R3: When bits 7:6 are 10 (timer mode) and the run bit is set, the counter advances once per tick of the selected source. Bit 5 = 0 selects `rtc_tick` and bit 5 = 1 selects `sys_tick`. The other source has no effect.
- R4: When the run bit (bit 4) is 0, the counter holds its value.
- R5: When bits 7:6 are 01 (event mode) and the run bit is set, the counter advances once per pin edge of one polarity. Bit 3 = 0 counts rising edges and bit 3 = 1 counts falling edges.
- R6: When bits 7:6 are 11 (pulse-width mode), the counter advances on each selected tick while the pin phase is open. With bit 3 = 1, a rising edge opens the phase and the next falling edge closes it. With bit 3 = 0, a falling edge opens it and the next rising edge closes it.
- R7: After reset, the control register, the reload value, the counter and the overflow flag are all zero.
- R8: In pulse-width mode, the closing edge clears the run bit. Later pin activity leaves the captured count unchanged.
- R9: A write to the reload register (address 1) also loads the counter, but only while the run bit is 0. While the counter runs, such a write changes only the reload value.
- R10: An advance from all ones loads the counter with the reload value and sets `ovf_flag`.
- R11: `ovf_flag` stays set until a write to address 3 with data bit 0 = 1. A write to address 3 with bit 0 = 0 leaves the flag set. Address 3 reads the flag in bit 0.
- R12: The counter value is readable at address 2. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for both read and write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the addressed register, combinational |
| rtc_tick | input | 1 | Slow internal tick enable (source 0) |
| sys_tick | input | 1 | Fast internal tick enable (source 1) |
| tmr_pin | input | 1 | External timer/event input, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Read data is combinational, so the bench samples it in the same cycle it sets the address, well before the next clock edge. A register write, a tick advance, a reload on overflow and the setting of the flag all show up after the single clock edge that takes them, so they are checked at the following falling edge. A pin transition reaches the edge detector only after two synchronizer edges and is counted on the edge after that. For this reason the bench waits at least four cycles after its last pin change before reading a count. It chooses pulse lengths so that the expected pulse-width count is simply the number of cycles the pin stayed in the open phase.

// File: rtl/tmr_pkg.sv
// Package: shared encodings for the timer/event counter.
// Assumes the control register layout is fixed at eight bits.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PRE  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int CTRL_W   = 8;
    localparam int BIT_EDGE = 3;
    localparam int BIT_RUN  = 4;
    localparam int BIT_SRC  = 5;
endpackage

// File: rtl/tmr_edge_sync.sv
// tmr_edge_sync: brings an asynchronous pin into the clk domain through
// STAGES flops, then flags one-cycle rising and falling edge pulses.
// Assumes STAGES >= 1 and pin pulses wider than one clock period.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First synchronizer flop samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                // Each later flop re-samples the one before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/tmr_ctrl_reg.sv
// tmr_ctrl_reg: holds the control fields and the pulse-width phase state,
// and decides in each cycle whether the counter advances.
// Assumes rise/fall are already synchronous single-cycle pulses.
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wd,
    input  logic              rise,
    input  logic              fall,
    input  logic              rtc_tick,
    input  logic              sys_tick,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              run,
    output logic              cnt_inc
);
    tmr_mode_e mode_q;
    logic      src_q, run_q, edge_q, pw_open;
    logic      tick, open_edge, close_edge, evt_edge, pw_close;

    assign tick       = src_q ? sys_tick : rtc_tick;
    assign open_edge  = edge_q ? rise : fall;
    assign close_edge = edge_q ? fall : rise;
    assign evt_edge   = edge_q ? fall : rise;
    assign pw_close   = (mode_q == MODE_PULSE) && run_q && pw_open && close_edge;

    // Pick the advance condition for the current mode.
    always_comb begin
        case (mode_q)
            MODE_EVENT: cnt_inc = run_q & evt_edge;
            MODE_TIMER: cnt_inc = run_q & tick;
            MODE_PULSE: cnt_inc = run_q & pw_open & tick;
            default:    cnt_inc = 1'b0;
        endcase
    end

    // Control fields; software write wins over the hardware run clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            src_q  <= 1'b0;
            run_q  <= 1'b0;
            edge_q <= 1'b0;
        end else if (ctrl_we) begin
            mode_q <= tmr_mode_e'(ctrl_wd[7:6]);
            src_q  <= ctrl_wd[BIT_SRC];
            run_q  <= ctrl_wd[BIT_RUN];
            edge_q <= ctrl_wd[BIT_EDGE];
        end else if (pw_close) begin
            run_q  <= 1'b0;
        end
    end

    // Pulse-width phase tracker: opens on the start edge, closes on the stop edge.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_we) begin
            pw_open <= 1'b0;
        end else if (mode_q == MODE_PULSE && run_q) begin
            if (!pw_open && open_edge)      pw_open <= 1'b1;
            else if (pw_open && close_edge) pw_open <= 1'b0;
        end else begin
            pw_open <= 1'b0;
        end
    end

    assign ctrl_q = {mode_q, src_q, run_q, edge_q, 3'b000};
    assign run    = run_q;

    assert_pw_close_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PULSE && run_q && pw_open && close_edge && !ctrl_we) |=> !run_q);

    assert_pw_open_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pw_open && !ctrl_we && !(run_q && open_edge)) |=> !pw_open);
endmodule

// File: rtl/tmr_count_core.sv
// tmr_count_core: up counter with reload register and sticky overflow flag.
// Assumes inc is only raised while the counter is running.
module tmr_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             run,
    input  logic             pre_we,
    input  logic             clr_we,
    input  logic [CNT_W-1:0] wd,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] pre_q,
    output logic             flag_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;
    assign wrap = inc && (cnt_q == CNT_MAX);

    // Counter: direct load while stopped, otherwise advance or reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (pre_we && !run) cnt_q <= wd;
        else if (wrap)           cnt_q <= pre_q;
        else if (inc)            cnt_q <= cnt_q + 1'b1;
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_we) pre_q <= wd;
    end

    // Sticky overflow flag; a wrap in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (wrap)            flag_q <= 1'b1;
        else if (clr_we && wd[0]) flag_q <= 1'b0;
    end

    assert_wrap_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == CNT_MAX && !(pre_we && !run)) |=> (cnt_q == $past(pre_q)) && flag_q);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(clr_we && wd[0])) |=> flag_q);
endmodule

// File: rtl/tmr_evt_ctr.sv
// tmr_evt_ctr: top of the timer/event counter with pulse-width capture.
// Assumes CNT_W >= 8 so the control byte fits the data bus; reads are combinational.
module tmr_evt_ctr
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             rtc_tick,
    input  logic             sys_tick,
    input  logic             tmr_pin,
    output logic             ovf_flag
);
    logic              rise, fall, run, cnt_inc, flag_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q, pre_q;
    logic              ctrl_we, pre_we, clr_we;

    assign ctrl_we = bus_we && (bus_addr == ADDR_CTRL);
    assign pre_we  = bus_we && (bus_addr == ADDR_PRE);
    assign clr_we  = bus_we && (bus_addr == ADDR_FLAG);

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (tmr_pin),
        .rise (rise),
        .fall (fall)
    );

    tmr_ctrl_reg ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .ctrl_wd (bus_wdata[CTRL_W-1:0]),
        .rise    (rise),
        .fall    (fall),
        .rtc_tick(rtc_tick),
        .sys_tick(sys_tick),
        .ctrl_q  (ctrl_q),
        .run     (run),
        .cnt_inc (cnt_inc)
    );

    tmr_count_core #(.CNT_W(CNT_W)) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .run   (run),
        .pre_we(pre_we),
        .clr_we(clr_we),
        .wd    (bus_wdata),
        .cnt_q (cnt_q),
        .pre_q (pre_q),
        .flag_q(flag_q)
    );

    // Read mux over the four registers.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl_q);
            ADDR_PRE:  bus_rdata = pre_q;
            ADDR_CNT:  bus_rdata = cnt_q;
            default:   bus_rdata = CNT_W'(flag_q);
        endcase
    end

    assign ovf_flag = flag_q;

    assert_off_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7:6] == 2'b00 && !pre_we) |=> $stable(cnt_q));

    assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[BIT_RUN] && !pre_we) |=> $stable(cnt_q));

    assert_running_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_RUN] && pre_we && !cnt_inc) |=> $stable(cnt_q));
endmodule

// File: tb/tmr_evt_ctr_tb_top.sv
module tmr_evt_ctr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rtc_tick = 1'b0;
    logic       sys_tick = 1'b0;
    logic       tmr_pin = 1'b0;
    logic       ovf_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    tmr_evt_ctr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
        .sys_tick(sys_tick), .tmr_pin(tmr_pin), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_rtc();
        @(negedge clk); rtc_tick = 1'b1;
        @(negedge clk); rtc_tick = 1'b0;
    endtask

    task automatic pulse_sys();
        @(negedge clk); sys_tick = 1'b1;
        @(negedge clk); sys_tick = 1'b0;
    endtask

    // Stop the counter and load it with a start value.
    task automatic setup(input logic [7:0] start);
        wr(2'd0, 8'h00);
        wr(2'd1, start);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R7: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); check("R7 reset register", d, 8'h00);
        end
        check("R7 reset flag", {7'd0, ovf_flag}, 8'h00);

        // R1: low control bits read zero
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R1 ctrl readback", d, 8'hF8);
        wr(2'd0, 8'h4F); rd(2'd0, d); check("R1 ctrl readback", d, 8'h48);

        // R3: timer mode sweep over source and tick counts
        for (int s = 0; s < 2; s++)
            for (int ra = 0; ra < 6; ra += 3)
                for (int sb = 0; sb < 8; sb += 3) begin
                    setup(8'h00);
                    wr(2'd0, {2'b10, 1'(s), 1'b1, 1'b0, 3'b000});
                    for (int i = 0; i < ra; i++) pulse_rtc();
                    for (int i = 0; i < sb; i++) pulse_sys();
                    for (int i = 0; i < 2; i++) begin pulse_rtc(); pulse_sys(); end
                    rd(2'd2, d);
                    check("R3 timer count", d, 8'(s ? sb + 2 : ra + 2));
                end

        // R2: mode 00 does not count
        setup(8'h00);
        wr(2'd0, 8'h38);
        for (int i = 0; i < 5; i++) begin pulse_sys(); pulse_rtc(); end
        tmr_pin = 1'b1; idle(5); tmr_pin = 1'b0; idle(5);
        rd(2'd2, d); check("R2 off mode hold", d, 8'h00);

        // R9/R4: preload loads the counter when stopped, then stopped counter holds
        setup(8'h33);
        rd(2'd2, d); check("R9 stopped preload loads count", d, 8'h33);
        wr(2'd0, 8'hA0);
        for (int i = 0; i < 5; i++) pulse_sys();
        rd(2'd2, d); check("R4 stopped hold", d, 8'h33);

        // R9: preload while running leaves count alone
        wr(2'd0, 8'hB0);
        wr(2'd1, 8'h55);
        rd(2'd2, d); check("R9 running preload no load", d, 8'h33);
        rd(2'd1, d); check("R9 preload value", d, 8'h55);

        // R12: writes to the count address are ignored
        wr(2'd2, 8'h99);
        rd(2'd2, d); check("R12 count write ignored", d, 8'h33);

        // R5: event mode, both polarities; 3 rises and 2 falls
        for (int e = 0; e < 2; e++) begin
            setup(8'h00);
            tmr_pin = 1'b0; idle(5);
            wr(2'd0, {2'b01, 1'b0, 1'b1, 1'(e), 3'b000});
            for (int p = 0; p < 3; p++) begin
                tmr_pin = 1'b1; idle(4);
                if (p < 2) begin tmr_pin = 1'b0; idle(4); end
            end
            idle(5);
            rd(2'd2, d); check("R5 event edges", d, e ? 8'h02 : 8'h03);
            tmr_pin = 1'b0; idle(5);
        end

        // R6/R8: pulse-width capture for both polarities and several widths
        for (int pol = 0; pol < 2; pol++)
            for (int k = 1; k < 10; k += 3) begin
                setup(8'h00);
                tmr_pin = pol ? 1'b0 : 1'b1; idle(6);
                sys_tick = 1'b1;
                wr(2'd0, {2'b11, 1'b1, 1'b1, 1'(pol), 3'b000});
                idle(3);
                tmr_pin = ~tmr_pin; idle(k);
                tmr_pin = ~tmr_pin; idle(6);
                rd(2'd2, d); check("R6 pulse width", d, 8'(k));
                rd(2'd0, d); check("R8 run cleared", d, {2'b11, 1'b1, 1'b0, 1'(pol), 3'b000});
                tmr_pin = ~tmr_pin; idle(4); tmr_pin = ~tmr_pin; idle(6);
                rd(2'd2, d); check("R8 capture held", d, 8'(k));
                sys_tick = 1'b0;
            end

        // R10/R11: wrap from all ones reloads and sets the sticky flag
        setup(8'hF0);
        wr(2'd0, 8'hB0);
        for (int i = 0; i < 15; i++) pulse_sys();
        check("R10 no flag before wrap", {7'd0, ovf_flag}, 8'h00);
        pulse_sys();
        rd(2'd2, d); check("R10 reload on wrap", d, 8'hF0);
        check("R10 flag set", {7'd0, ovf_flag}, 8'h01);
        for (int i = 0; i < 3; i++) pulse_sys();
        rd(2'd2, d); check("R10 count after reload", d, 8'hF3);
        rd(2'd3, d); check("R11 flag sticky", d, 8'h01);
        wr(2'd3, 8'h00);
        check("R11 clear with bit0 0 ignored", {7'd0, ovf_flag}, 8'h01);
        wr(2'd3, 8'h01);
        check("R11 flag cleared", {7'd0, ovf_flag}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule